// File: doc/BRIEF.md
# Ternary Gate Cascade Peephole Reducer

This block shortens a finished ternary reversible gate cascade. Each gene in the cascade names a control line, a target line and one of the six permutations of the values {0,1,2}. After a start strobe the block walks the gene memory from address 0, composes neighbouring genes that act on exactly the same control and target lines into one gene, deletes genes that come out as the identity, and writes the survivors back in place. Walks are repeated until one of them changes nothing. The block then reports the new gene count with a one-cycle done pulse.

The gene memory is external. The block reads it through a combinational read port and writes through a separate write port. A write always lands at an address at or below the one being read, so the rewrite is safe in place. Cost after reduction is one unit per surviving gene, and delay is one gate time per surviving gene.

Top module: `ternary_peephole`

## Requirements
- R1: After reset, done is 0, reduced_count is 0 and wr_en is 0.
- R2: A gene is laid out as control line in bits [8:6], target line in [5:3] and type in [2:0]. Types are: 0 identity, 1 add one, 2 add two, 3 the map 0↔1, 4 the map 0↔2, 5 the map 1↔2. Codes 0, 6 and 7 are dropped from the output, and every written gene has a type from 1 to 5.
- R3: Two adjacent uncontrolled genes (control equal to target) on the same line become one gene whose type is the second permutation applied after the first. For example, add one followed by add one gives add two.
- R4: Two adjacent genes with the same control line and the same target line are composed in the same way. Genes that share a target but have different control lines are left apart.
- R5: A pair that composes to identity is deleted. Such pairs are add one with add two, and each of the three swap maps with itself.
- R6: Surviving genes are stored contiguously from address 0, in their original relative order. Only genes that are adjacent in the current cascade are merged.
- R7: Walks repeat until one makes no change, so cancellations nested to any depth collapse. For example, X Y Y' X' reduces to nothing. The final count is never larger than the input count.
- R8: done is high for exactly one cycle at the end. reduced_count is valid with done and holds its value until the next completion.
- R9: A start strobe while a reduction is in progress is ignored.
- R10: A gene count of zero completes with reduced_count equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin reducing the cascade held in the gene memory |
| gene_count | input | 6 | Number of genes at start (at most DEPTH) |
| done | output | 1 | One-cycle completion pulse |
| reduced_count | output | 6 | Gene count after reduction |
| rd_addr | output | 5 | Gene memory read address |
| rd_data | input | 9 | Gene read from rd_addr, same cycle |
| wr_en | output | 1 | Gene memory write enable |
| wr_addr | output | 5 | Gene memory write address |
| wr_data | output | 9 | Gene to write |

## Verification
A wrong composition entry or a wrongly held pending gene shows up as a wrong type or a missing gene in memory once the run completes. A wrong merge key shows up the same way, and so does an early stop of the repeat loop, because the memory image and the count then differ from a fully reduced normal form. The bench computes that normal form with a stack, which is an independent method. Write-pointer faults break contiguity or order, and a broken done pulse shows up within one cycle of completion.

// File: rtl/ternary_peephole.sv
module ternary_peephole #(
  parameter int DEPTH = 32,
  parameter int LW = 3,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int GW = 2 * LW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] gene_count,
  output logic          done,
  output logic [CW-1:0] reduced_count,
  output logic [AW-1:0] rd_addr,
  input  logic [GW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [GW-1:0] wr_data
);

  function automatic logic [5:0] perm(input logic [2:0] t);
    case (t)
      3'd1: perm = {2'd0, 2'd2, 2'd1};
      3'd2: perm = {2'd1, 2'd0, 2'd2};
      3'd3: perm = {2'd2, 2'd0, 2'd1};
      3'd4: perm = {2'd0, 2'd1, 2'd2};
      3'd5: perm = {2'd1, 2'd2, 2'd0};
      default: perm = {2'd2, 2'd1, 2'd0};
    endcase
  endfunction

  function automatic logic [1:0] img(input logic [5:0] p, input logic [1:0] x);
    case (x)
      2'd0: img = p[1:0];
      2'd1: img = p[3:2];
      default: img = p[5:4];
    endcase
  endfunction

  function automatic logic [2:0] compose(input logic [2:0] a, input logic [2:0] b);
    logic [5:0] pa, pb, pc;
    pa = perm(a);
    pb = perm(b);
    pc = {img(pb, pa[5:4]), img(pb, pa[3:2]), img(pb, pa[1:0])};
    compose = 3'd0;
    for (int t = 1; t < 6; t++)
      if (perm(3'(t)) == pc) compose = 3'(t);
  endfunction

  localparam logic [1:0] S_IDLE = 2'd0, S_SCAN = 2'd1;

  logic [1:0]    state;
  logic [CW-1:0] ri, n, wp;
  logic [GW-1:0] held;
  logic          hv, chg;
  logic          busy;

  logic [2:0]    gt, ct;
  logic          gid, same, at_end, push;
  logic [CW-1:0] newcnt;

  assign busy   = (state == S_SCAN);
  assign at_end = (ri == n);
  assign gt     = rd_data[2:0];
  assign gid    = (gt == 3'd0) || (gt > 3'd5);
  assign same   = hv && (rd_data[GW-1:3] == held[GW-1:3]);
  assign ct     = compose(held[2:0], gt);
  assign push   = !at_end && !gid && !same;
  assign newcnt = wp + CW'(hv);

  assign rd_addr = ri[AW-1:0];
  assign wr_en   = busy && hv && (at_end || push);
  assign wr_addr = wp[AW-1:0];
  assign wr_data = held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      ri            <= '0;
      n             <= '0;
      wp            <= '0;
      held          <= '0;
      hv            <= 1'b0;
      chg           <= 1'b0;
      done          <= 1'b0;
      reduced_count <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_SCAN;
            n     <= gene_count;
            ri    <= '0;
            wp    <= '0;
            hv    <= 1'b0;
            chg   <= 1'b0;
          end
        end
        default: begin
          if (!at_end) begin
            ri <= ri + CW'(1);
            if (gid) begin
              chg <= 1'b1;
            end else if (same) begin
              chg <= 1'b1;
              if (ct == 3'd0) hv <= 1'b0;
              else held[2:0] <= ct;
            end else begin
              if (hv) wp <= wp + CW'(1);
              held <= rd_data;
              hv   <= 1'b1;
            end
          end else if (chg) begin
            n   <= newcnt;
            ri  <= '0;
            wp  <= '0;
            hv  <= 1'b0;
            chg <= 1'b0;
          end else begin
            state         <= S_IDLE;
            done          <= 1'b1;
            reduced_count <= newcnt;
            hv            <= 1'b0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ternary_peephole_chk.sv
module ternary_peephole_chk #(
  parameter int DEPTH = 32,
  parameter int LW = 3,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int GW = 2 * LW + 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] gene_count,
  input logic          done,
  input logic [CW-1:0] reduced_count,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [GW-1:0] wr_data,
  input logic          busy
);

  logic [CW-1:0] n0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) n0 <= '0;
    else if (start && !busy) n0 <= gene_count;
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_written_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[2:0] != 3'd0 && wr_data[2:0] <= 3'd5));

  assert_write_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> reduced_count <= n0);

  assert_write_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> CW'(wr_addr) < n0);

endmodule

bind ternary_peephole ternary_peephole_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .gene_count(gene_count),
  .done(done), .reduced_count(reduced_count), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy)
);

// File: tb/ternary_peephole_tb.sv
module ternary_peephole_tb;
  localparam int DEPTH = 32;
  localparam int AW = 5;
  localparam int CW = 6;
  localparam int GW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] gene_count = '0;
  logic          done;
  logic [CW-1:0] reduced_count;
  logic [AW-1:0] rd_addr;
  logic [GW-1:0] rd_data;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [GW-1:0] wr_data;

  logic [GW-1:0] mem [DEPTH];
  logic [GW-1:0] seq [DEPTH];
  logic [GW-1:0] stk [DEPTH];
  int            sp;
  int            checks = 0;
  int            fails = 0;

  always #2 clk = ~clk;

  assign rd_data = mem[rd_addr];
  always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

  ternary_peephole u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .gene_count(gene_count),
    .done(done), .reduced_count(reduced_count), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic int apply_t(input int t, input int x);
    case (t)
      1: apply_t = (x + 1) % 3;
      2: apply_t = (x + 2) % 3;
      3: apply_t = (2 * x + 1) % 3;
      4: apply_t = (2 * x + 2) % 3;
      5: apply_t = (2 * x) % 3;
      default: apply_t = x;
    endcase
  endfunction

  function automatic int comp_t(input int a, input int b);
    comp_t = 0;
    for (int t = 1; t < 6; t++)
      if (apply_t(t, 0) == apply_t(b, apply_t(a, 0)) &&
          apply_t(t, 1) == apply_t(b, apply_t(a, 1)) &&
          apply_t(t, 2) == apply_t(b, apply_t(a, 2)))
        comp_t = t;
  endfunction

  function automatic logic [GW-1:0] gene(input int c, input int g, input int t);
    gene = {3'(c), 3'(g), 3'(t)};
  endfunction

  task automatic model(input int n);
    sp = 0;
    for (int i = 0; i < n; i++) begin
      int t;
      t = int'(seq[i][2:0]);
      if (t == 0 || t > 5) continue;
      if (sp > 0 && stk[sp-1][8:3] == seq[i][8:3]) begin
        int c;
        c = comp_t(int'(stk[sp-1][2:0]), t);
        if (c == 0) sp--;
        else stk[sp-1][2:0] = 3'(c);
      end else begin
        stk[sp] = seq[i];
        sp++;
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int n, input string req, input bit poke);
    int waited;
    for (int i = 0; i < n; i++) mem[i] = seq[i];
    model(n);
    @(negedge clk);
    gene_count = CW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      gene_count = CW'(0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, req, int'(done), 1);
    check(int'(reduced_count) == sp, req, int'(reduced_count), sp);
    for (int i = 0; i < sp && i < DEPTH; i++)
      check(mem[i] == stk[i], req, int'(mem[i]), int'(stk[i]));
    @(negedge clk);
    check(done == 1'b0, "R8", int'(done), 0);
    check(int'(reduced_count) == sp, "R8", int'(reduced_count), sp);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", int'(done), 0);
    check(reduced_count == '0, "R1", int'(reduced_count), 0);
    check(wr_en == 1'b0, "R1", int'(wr_en), 0);
    rst_n = 1'b1;

    run(0, "R10", 1'b0);

    seq[0] = gene(1, 1, 1); seq[1] = gene(1, 1, 1);
    run(2, "R3", 1'b0);

    seq[0] = gene(0, 2, 3); seq[1] = gene(0, 2, 1); seq[2] = gene(1, 2, 1);
    run(3, "R4", 1'b0);

    seq[0] = gene(2, 2, 1); seq[1] = gene(2, 2, 2);
    seq[2] = gene(0, 1, 4); seq[3] = gene(0, 1, 4);
    seq[4] = gene(3, 3, 5); seq[5] = gene(3, 3, 5);
    run(6, "R5", 1'b0);

    seq[0] = gene(0, 0, 0); seq[1] = gene(1, 2, 0); seq[2] = gene(2, 2, 3);
    run(3, "R2", 1'b0);

    seq[0] = gene(0, 0, 1); seq[1] = gene(1, 1, 3); seq[2] = gene(0, 0, 2);
    seq[3] = gene(2, 1, 5);
    run(4, "R6", 1'b0);

    seq[0] = gene(0, 0, 1); seq[1] = gene(1, 1, 3); seq[2] = gene(2, 0, 4);
    seq[3] = gene(2, 0, 4); seq[4] = gene(1, 1, 3); seq[5] = gene(0, 0, 2);
    run(6, "R7", 1'b0);

    seq[0] = gene(0, 0, 1); seq[1] = gene(1, 0, 2); seq[2] = gene(1, 0, 2);
    run(3, "R9", 1'b1);

    for (int i = 0; i < DEPTH; i++) seq[i] = gene(i % 4, (i + 1) % 4, 1 + (i % 5));
    run(DEPTH, "R6", 1'b0);

    for (int k = 0; k < 60; k++) begin
      int n;
      n = int'($urandom % (DEPTH + 1));
      for (int i = 0; i < n; i++) begin
        int c, g;
        c = int'($urandom % 3);
        g = ($urandom % 2 == 0) ? c : int'($urandom % 3);
        seq[i] = gene(c, g, int'($urandom % 6));
      end
      run(n, "R7", 1'b0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule